// File: doc/BRIEF.md
# Shared ROM and SRAM External Bus Sequencer

This block drives one external memory bus that is shared by a 16-bit ROM and a working SRAM. The SRAM may be 8 or 16 bits wide. An internal requester hands over one word command at a time: a 19-bit word address, a region select (ROM or RAM), a direction and, for writes, a 16-bit word. The block then runs a fixed six-clock word cycle on the pins and answers with a one-clock done pulse. For reads, the full 16-bit word appears on `rdata` in the same cycle.

In 8-bit SRAM mode a word access becomes two byte transfers inside that same six-clock cycle. The low byte goes first, on the low data lane. The byte-select pin then acts as the lowest RAM address bit and rises for the high byte. A read holds output enable low across both bytes. A write gives two write-enable pulses. A write aimed at the ROM region never reaches the pins and is answered with an error flag. Address, byte select and write data keep their values between accesses, so idle cycles cause no pin activity.

Top module: `ext_mem_ctrl`

## Requirements
- R1: While reset is held, and after it, both chip selects, output enable and write enable are high, `dq_oe` is 0, `req_ready` is 1, `done` and `wr_err` are 0, and `mem_addr`, `bsel`, `dq_out` and `rdata` are 0.
- R2: A ROM read (`req_rom`=1, `req_write`=0) holds `rom_cs_n` low for the six clocks after acceptance, with `ram_cs_n` high. `oe_n` is low in clocks 3 to 6. The full 16-bit `dq_in` seen in clock 6 is returned, whatever `cfg_ram8` is, and `bsel` is left unchanged.
- R3: A 16-bit RAM read (`cfg_ram8`=0) has the same timing on `ram_cs_n` and returns the full 16-bit `dq_in` seen in clock 6.
- R4: An 8-bit RAM read (`cfg_ram8`=1) holds `bsel` at 0 in clocks 1 to 4 and at 1 in clocks 5 and 6, with `oe_n` low without a break in clocks 3 to 6. `rdata` is {`dq_in[7:0]` of clock 6, `dq_in[7:0]` of clock 4}.
- R5: A 16-bit RAM write drives `dq_out` with the word and `dq_oe`=1 in clocks 2 to 6, and pulls `we_n` low in clocks 3 to 5.
- R6: An 8-bit RAM write pulls `we_n` low in clocks 2 and 5. `dq_oe` is 1 in clocks 1 to 6. `dq_out[7:0]` carries the low byte in clocks 1 to 3 and the high byte in clocks 4 to 6, and `bsel` rises in clock 4.
- R7: A write with `req_rom`=1 changes no memory pin and no held value. In the clock after acceptance `done` and `wr_err` are both 1 for one cycle.
- R8: `req_ready` is low during the six access clocks. `done` is 1 for exactly the one clock that follows them, with `req_ready` already 1, and a new request may be accepted in that clock.
- R9: Whenever no access is running, `mem_addr`, `bsel`, `dq_out` and `rdata` keep their last values.
- R10: `dq_oe` is 1 only while `ram_cs_n` is low and `oe_n` is high.
- R11: `oe_n` falls at least two clocks after a chip select falls and is never low together with `we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ram8 | input | 1 | 1 = SRAM is 8 bits wide, 0 = 16 bits |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rom | input | 1 | 1 = ROM region, 0 = RAM region |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Block can accept a request this clock |
| done | output | 1 | One-clock completion pulse |
| wr_err | output | 1 | Pulses with done for a dropped ROM write |
| rdata | output | 16 | Read word, valid with done |
| mem_addr | output | 19 | External word address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | RAM write enable, active low |
| bsel | output | 1 | RAM byte select / lowest byte address |
| dq_out | output | 16 | Data bus, outgoing value |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data bus, incoming value |

## Verification
A request accepted at one rising edge puts its first pin state on the bus in the clock right after that edge. The pins then follow the access schedule for six clocks, and `done` with `rdata` comes in the seventh. A dropped ROM write shows `done` and `wr_err` in the first clock after acceptance. The bench lays out this schedule as a queue of expected pin states when it issues the request and takes one entry per clock, comparing it in the middle of the cycle. When the queue is empty it expects idle values that hold what the last access left. Because of this, every pin, including the held address, byte select and write data, is checked in the exact clock where it is due and in every idle clock after it.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  localparam int unsigned PH_W = 3;

  // word cycle schedule, counted in clocks after acceptance (0-based)
  localparam logic [PH_W-1:0] PH_OE_ON  = 3'd2;  // output enable falls
  localparam logic [PH_W-1:0] PH_LO_CAP = 3'd3;  // 8-bit read: low byte sampled
  localparam logic [PH_W-1:0] PH_W8_SW  = 3'd2;  // 8-bit write: switch to high byte
  localparam logic [PH_W-1:0] PH_W8_P1  = 3'd1;  // 8-bit write: first pulse
  localparam logic [PH_W-1:0] PH_W8_P2  = 3'd4;  // 8-bit write: second pulse
  localparam logic [PH_W-1:0] PH_W16_LO = 3'd2;  // 16-bit write pulse start
  localparam logic [PH_W-1:0] PH_W16_HI = 3'd4;  // 16-bit write pulse end
  localparam logic [PH_W-1:0] PH_LAST   = 3'd5;

  typedef struct packed {
    logic wr;
    logic rom;
    logic ram8;
  } acc_t;

endpackage

// File: rtl/memctl_seq.sv
module memctl_seq
  import memctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_ram8,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_rom,
  output logic            ready,
  output logic            load,
  output logic            load_ram8,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output acc_t            acc,
  output logic            done,
  output logic            wr_err
);

  logic            accept, drop;
  logic            busy_d, done_d, err_d;
  logic [PH_W-1:0] phase_d;
  acc_t            acc_d;

  assign ready     = !busy;
  assign accept    = req_valid && !busy;
  assign drop      = accept && req_write && req_rom;
  assign load      = accept && !drop;
  assign load_ram8 = cfg_ram8 && !req_rom;

  always_comb begin
    busy_d  = busy;
    phase_d = phase;
    acc_d   = acc;
    done_d  = 1'b0;
    err_d   = drop;
    if (load) begin
      busy_d  = 1'b1;
      phase_d = '0;
      acc_d   = '{wr: req_write, rom: req_rom, ram8: load_ram8};
    end else if (busy) begin
      if (phase == PH_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        phase_d = phase + 1'b1;
      end
    end
    if (drop) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= '0;
      acc    <= '0;
      done   <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      busy   <= busy_d;
      phase  <= phase_d;
      acc    <= acc_d;
      done   <= done_d;
      wr_err <= err_d;
    end
  end

endmodule

// File: rtl/memctl_strobe.sv
module memctl_strobe
  import memctl_pkg::*;
(
  input  logic            busy,
  input  logic [PH_W-1:0] phase,
  input  acc_t            acc,
  output logic            rom_cs_n,
  output logic            ram_cs_n,
  output logic            oe_n,
  output logic            we_n,
  output logic            dq_oe
);

  logic rd_act, wr_act, we_on, drv_on;

  assign rd_act = busy && !acc.wr;
  assign wr_act = busy && acc.wr;

  always_comb begin
    if (acc.ram8) begin
      we_on  = (phase == PH_W8_P1) || (phase == PH_W8_P2);
      drv_on = 1'b1;
    end else begin
      we_on  = (phase >= PH_W16_LO) && (phase <= PH_W16_HI);
      drv_on = (phase != '0);
    end
  end

  assign rom_cs_n = !(busy && acc.rom);
  assign ram_cs_n = !(busy && !acc.rom);
  assign oe_n     = !(rd_act && (phase >= PH_OE_ON));
  assign we_n     = !(wr_act && we_on);
  assign dq_oe    = wr_act && drv_on;

endmodule

// File: rtl/memctl_data.sv
module memctl_data
  import memctl_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_ram8,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            busy,
  input  logic [PH_W-1:0] phase,
  input  acc_t            acc,
  input  logic [DW-1:0]   dq_in,
  output logic [AW-1:0]   mem_addr,
  output logic            bsel,
  output logic [DW-1:0]   dq_out,
  output logic [DW-1:0]   rdata
);

  localparam int unsigned BW = DW / 2;

  logic [AW-1:0] addr_d;
  logic          bsel_d;
  logic [DW-1:0] dq_d, rdata_d;
  logic [BW-1:0] lo_q, lo_d;
  logic          rd8, wr8;

  assign rd8 = busy && acc.ram8 && !acc.wr;
  assign wr8 = busy && acc.ram8 && acc.wr;

  always_comb begin
    addr_d  = mem_addr;
    bsel_d  = bsel;
    dq_d    = dq_out;
    lo_d    = lo_q;
    rdata_d = rdata;
    if (load) begin
      addr_d = req_addr;
      if (load_ram8) bsel_d = 1'b0;
      if (req_write) dq_d = req_wdata;
    end
    if ((rd8 && phase == PH_LO_CAP) || (wr8 && phase == PH_W8_SW))
      bsel_d = 1'b1;
    if (wr8 && phase == PH_W8_SW)
      dq_d = {dq_out[DW-1:BW], dq_out[DW-1:BW]};
    if (rd8 && phase == PH_LO_CAP)
      lo_d = dq_in[BW-1:0];
    if (busy && !acc.wr && phase == PH_LAST)
      rdata_d = acc.ram8 ? {dq_in[BW-1:0], lo_q} : dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      bsel     <= 1'b0;
      dq_out   <= '0;
      lo_q     <= '0;
      rdata    <= '0;
    end else begin
      mem_addr <= addr_d;
      bsel     <= bsel_d;
      dq_out   <= dq_d;
      lo_q     <= lo_d;
      rdata    <= rdata_d;
    end
  end

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import memctl_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ram8,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_rom,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic          wr_err,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          rom_cs_n,
  output logic          ram_cs_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          bsel,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[SYNC_STAGES-1];

  logic            load, load_ram8, busy;
  logic [PH_W-1:0] phase;
  acc_t            acc;

  memctl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_ram8  (cfg_ram8),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_rom   (req_rom),
    .ready     (req_ready),
    .load      (load),
    .load_ram8 (load_ram8),
    .busy      (busy),
    .phase     (phase),
    .acc       (acc),
    .done      (done),
    .wr_err    (wr_err)
  );

  memctl_strobe u_strobe (
    .busy     (busy),
    .phase    (phase),
    .acc      (acc),
    .rom_cs_n (rom_cs_n),
    .ram_cs_n (ram_cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_oe    (dq_oe)
  );

  memctl_data #(.AW(AW), .DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (load),
    .load_ram8 (load_ram8),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .phase     (phase),
    .acc       (acc),
    .dq_in     (dq_in),
    .mem_addr  (mem_addr),
    .bsel      (bsel),
    .dq_out    (dq_out),
    .rdata     (rdata)
  );

endmodule

// File: rtl/memctl_chk.sv
module memctl_chk #(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          wr_err,
  input logic [AW-1:0] mem_addr,
  input logic          rom_cs_n,
  input logic          ram_cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          bsel,
  input logic          dq_oe
);

  // R2
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> ram_cs_n);

  // R4
  bsel_rise_in_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsel) |-> !ram_cs_n);

  // R5
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);

  // R6
  wr_data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(dq_oe));

  // R6
  we_only_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ram_cs_n && dq_oe));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (done && rom_cs_n && ram_cs_n));

  // R8
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R8
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> done);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(mem_addr) && $stable(bsel)));

  // R10
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ram_cs_n && oe_n));

  // R11
  oe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(!rom_cs_n || !ram_cs_n, 2));

  // R11
  oe_we_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n);

endmodule

bind ext_mem_ctrl memctl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .wr_err    (wr_err),
  .mem_addr  (mem_addr),
  .rom_cs_n  (rom_cs_n),
  .ram_cs_n  (ram_cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .bsel      (bsel),
  .dq_oe     (dq_oe)
);

// File: tb/test_ext_mem_ctrl.sv
`timescale 1ns/1ps
module test_ext_mem_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ram8 = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_rom = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, wr_err;
  logic [15:0] rdata;
  logic [18:0] mem_addr;
  logic        rom_cs_n, ram_cs_n, oe_n, we_n, bsel, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in;

  // device model on the bus
  logic        cur_ram8 = 1'b0;
  logic        cur_rom  = 1'b0;
  logic [15:0] rd_word  = '0;

  always #4 clk = ~clk;

  always_comb begin
    if (cur_ram8 && !cur_rom) dq_in = {8'hA5, bsel ? rd_word[15:8] : rd_word[7:0]};
    else                      dq_in = rd_word;
  end

  ext_mem_ctrl i_ext_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ram8(cfg_ram8),
    .req_valid(req_valid), .req_write(req_write), .req_rom(req_rom),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .wr_err(wr_err), .rdata(rdata), .mem_addr(mem_addr),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .oe_n(oe_n), .we_n(we_n),
    .bsel(bsel), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  typedef struct {
    logic        rom_cs_n, ram_cs_n, oe_n, we_n, dq_oe, bsel, ready, done, err;
    logic [18:0] addr;
    logic [15:0] dq, rdata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // model state held between accesses
  logic [18:0] m_addr  = '0;
  logic        m_bsel  = 1'b0;
  logic [15:0] m_dq    = '0;
  logic [15:0] m_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  function automatic exp_t idle_exp(string tag);
    exp_t e;
    e.rom_cs_n = 1; e.ram_cs_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0;
    e.bsel = m_bsel; e.ready = 1; e.done = 0; e.err = 0;
    e.addr = m_addr; e.dq = m_dq; e.rdata = m_rdata; e.tag = tag;
    return e;
  endfunction

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, name, $time, act, expv);
    end
  endtask

  string idle_tag = "R1";

  // compare every clock, mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (!finished) begin
        exp_t e;
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else                   e = idle_exp(idle_tag);
        chk(e.tag, "rom_cs_n", rom_cs_n, e.rom_cs_n);
        chk(e.tag, "ram_cs_n", ram_cs_n, e.ram_cs_n);
        chk("R11", "oe_n", oe_n, e.oe_n);
        chk(e.tag, "we_n", we_n, e.we_n);
        chk("R10", "dq_oe", dq_oe, e.dq_oe);
        chk(e.tag, "bsel", bsel, e.bsel);
        chk(e.tag, "mem_addr", mem_addr, e.addr);
        chk(e.tag, "dq_out", dq_out, e.dq);
        chk("R8", "req_ready", req_ready, e.ready);
        chk("R8", "done", done, e.done);
        chk(e.tag, "wr_err", wr_err, e.err);
        chk(e.tag, "rdata", rdata, e.rdata);
      end
    end
  end

  task automatic access(input bit wr, input bit rom, input bit ram8,
                        input logic [18:0] a, input logic [15:0] wd,
                        input logic [15:0] rw);
    string tg;
    bit    r8;
    @(negedge clk); #1;
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    idle_tag  = "R9";
    r8        = ram8 && !rom;
    cur_rom   = rom; cur_ram8 = ram8; rd_word = rw; cfg_ram8 = ram8;
    req_write = wr; req_rom = rom; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    if (wr && rom) begin
      // R7: dropped, no bus activity
      exp_t e = idle_exp("R7");
      e.done = 1; e.err = 1;
      exp_q.push_back(e);
    end else begin
      tg = rom ? "R2" : (wr ? (r8 ? "R6" : "R5") : (r8 ? "R4" : "R3"));
      for (int p = 0; p < 6; p++) begin
        exp_t e = idle_exp(tg);
        e.rom_cs_n = !rom; e.ram_cs_n = rom; e.ready = 0; e.addr = a;
        e.oe_n = !(!wr && p >= 2);
        if (wr) begin
          e.we_n  = r8 ? !(p == 1 || p == 4) : !(p >= 2 && p <= 4);
          e.dq_oe = r8 ? 1'b1 : (p >= 1);
          e.dq    = (r8 && p >= 3) ? {wd[15:8], wd[15:8]} : wd;
        end
        if (r8) e.bsel = wr ? (p >= 3) : (p >= 4);
        exp_q.push_back(e);
      end
      m_addr = a;
      if (r8) m_bsel = 1'b1;
      if (wr) m_dq = r8 ? {wd[15:8], wd[15:8]} : wd;
      else    m_rdata = rw;
      begin
        exp_t e = idle_exp("R8");
        e.done = 1;
        exp_q.push_back(e);
      end
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state observed while reset held and after release
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: ROM reads, also with 8-bit RAM configured
    access(0, 1, 0, 19'h00100, 16'h0000, 16'hBEEF);
    access(0, 1, 1, 19'h7FFFF, 16'h0000, 16'h1234);
    // R3: 16-bit RAM reads
    access(0, 0, 0, 19'h12345, 16'h0000, 16'hC3A5);
    // R4: 8-bit RAM reads
    access(0, 0, 1, 19'h00001, 16'h0000, 16'h5A96);
    access(0, 0, 1, 19'h40000, 16'h0000, 16'hFF00);
    // R5: 16-bit RAM writes
    access(1, 0, 0, 19'h2AAAA, 16'hA55A, 16'h0000);
    // R6: 8-bit RAM writes
    access(1, 0, 1, 19'h15555, 16'h7E81, 16'h0000);
    // R7: write to ROM dropped, held values kept
    access(1, 1, 0, 19'h00777, 16'h1111, 16'h0000);
    access(1, 1, 1, 19'h00778, 16'h2222, 16'h0000);
    // R8: back-to-back across patterns
    for (int i = 0; i < 8; i++) begin
      access(i[0], (i % 3) == 0, i[1], 19'(i * 19'h0F0F1), 16'(16'h1357 * (i + 1)),
             16'(16'h2468 ^ (i * 16'h1111)));
    end
    // R9: idle hold
    repeat (10) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule